// File: doc/BRIEF.md
# Tape Record Word Assembler

This block sits in the read path of a magnetic tape channel. It takes the characters of one tape record, one per cycle, and packs them into 24-bit memory words. For each word it raises a write strobe with an address and the data. Host memory, the record buffer and the tape drive are outside the block.

A command sets the direction (forward or reverse), the track format and the character mode (binary or BCD). It also carries a word count and a 15-bit start address. The two track formats are:

- 7-track: 6 data bits per character plus a check bit, four characters per word.
- 9-track: 8-bit bytes, three per word.

The block checks parity on every 7-track character. When the record ends part-way through a word, it pads the word with a stop character. When the transfer ends, it reports short-block, long-block and fill-word conditions against the word count. A status byte and a one-cycle done pulse close the transfer.

Top module: `tapeRecordPacker`

## Requirements
- R1: In 7-track forward mode, four characters form one word. The first character accepted goes to bits 23:18, the second to 17:12, the third to 11:6 and the fourth to 5:0. Only bits 5:0 of each character are stored.
- R2: In 7-track mode, bit 6 of a character is its check bit. Over chData[6:0], binary mode expects odd parity and BCD mode expects even parity. On a mismatch the bad character is discarded and the transfer terminates with the parity flag set. If the word already holds characters, it is stored with its unfilled positions zero. If it holds none, nothing more is stored.
- R3: When the record ends part-way through a 7-track word, every empty character position is filled with octal 74 and the word is stored.
- R4: In 9-track forward mode, three bytes form a word, first byte in bits 23:16. If the record ends after one byte, bits 15:0 become octal 07474. If it ends after two bytes, bits 7:0 become octal 074.
- R5: Forward mode writes at the current address and then steps it up by one. Reverse mode steps the address down by one and then writes. Addresses wrap modulo 2^15. Every data store decrements the word count. The transfer ends when the count reaches zero or when the character flagged chLast has been taken.
- R6: If the count reaches zero before the record ends, the short-block flag is set. If the record ends while count remains, the long-block flag is set.
- R7: In BCD mode, a long-block end adds one extra store of octal 74747474 at the next address in the transfer direction, and sets the fill flag.
- R8: In reverse mode, characters arrive starting from the record end and fill the word from the lowest slot upward. A short 7-track word is padded in its upper slots with octal 74. A short 9-track word has its upper bytes zero.
- R9: The status byte is laid out as follows: bit 0 terminate, bit 1 parity, bit 2 short, bit 3 long, bit 4 fill, bits 6:5 the number of characters in the last data word modulo 4, bit 7 busy. Status clears when a command is accepted. done is high for exactly one cycle at termination, and in that cycle busy is low and terminate is set.
- R10: A command with a word count of zero stores nothing. It raises done one cycle later with status 0x01.
- R11: chReady is high only while characters are being assembled. While busy, cmdValid is ignored. While idle, offered characters have no effect.
- R12: After reset, status, busy, done, chReady and wrValid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start a transfer (taken only when idle) |
| cmdReverse | input | 1 | Reverse read direction |
| cmdNineTrack | input | 1 | 9-track format when high, 7-track when low |
| cmdBcd | input | 1 | BCD mode when high, binary when low |
| cmdCount | input | CNT_W | Word count |
| cmdAddr | input | ADDR_W | Start address |
| chValid | input | 1 | Character offered |
| chData | input | 8 | Character (7-track: bit 6 check, bits 5:0 data) |
| chLast | input | 1 | Offered character is the last of the record |
| chReady | output | 1 | Block takes the offered character this cycle |
| wrValid | output | 1 | Word write strobe |
| wrAddr | output | ADDR_W | Word write address |
| wrData | output | 24 | Word write data |
| status | output | 8 | Status byte (layout in R9) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle termination pulse |

## Verification
The bench builds the block with its default 15-bit address and 15-bit count. This makes the wrap from 0x7FFF to 0 reachable in both directions with a short record. Word counts are kept small, so both short-block and long-block ends, BCD fill words, and parity stops at a word boundary and mid-word all occur in records of at most twelve characters.

// File: rtl/tapePkg.sv
package tapePkg;
  localparam int WORD_W = 24;
  localparam int STATUS_W = 8;
  localparam logic [5:0] FILL_CHAR = 6'o74;
  localparam logic [WORD_W-1:0] FILL_WORD = {4{FILL_CHAR}};

  typedef struct packed {
    logic start;
    logic take;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FILL = 2'd2
  } ctlState_t;
endpackage

// File: rtl/tapeWordDatapath.sv
module tapeWordDatapath
  import tapePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              nineTrack,
  input  logic              reverse,
  input  logic              bcd,
  input  logic [7:0]        chData,
  output logic              chBad,
  output logic              wordFull,
  output logic              hasChars,
  output logic [WORD_W-1:0] mergedWord,
  output logic [WORD_W-1:0] paddedWord,
  output logic [WORD_W-1:0] partialWord,
  output logic [1:0]        newCnt,
  output logic [1:0]        oldCnt
);
  logic [WORD_W-1:0] acc;
  logic [1:0]        pos;
  logic [2:0]        posNext;
  logic [2:0]        perWord;
  logic [4:0]        shAmt;
  logic [4:0]        pos6;
  logic [4:0]        pos8;
  logic [7:0]        charBits;

  always_comb begin
    perWord  = nineTrack ? 3'd3 : 3'd4;
    posNext  = {1'b0, pos} + 3'd1;
    charBits = nineTrack ? chData : {2'b00, chData[5:0]};
    // binary expects odd parity (xor 1), bcd expects even (xor 0)
    chBad    = !nineTrack && ((^chData[6:0]) == bcd);
    pos6     = {1'b0, pos, 2'b00} + {2'b00, pos, 1'b0};
    pos8     = {pos, 3'b000};
    if (nineTrack) shAmt = reverse ? pos8 : 5'd16 - pos8;
    else           shAmt = reverse ? pos6 : 5'd18 - pos6;
    mergedWord  = acc | ({16'b0, charBits} << shAmt);
    wordFull    = (posNext == perWord);
    hasChars    = (pos != 2'd0);
    partialWord = acc;
    newCnt      = posNext[1:0];
    oldCnt      = pos;
  end

  always_comb begin
    paddedWord = mergedWord;
    if (!nineTrack) begin
      for (int s = 0; s < 4; s++) begin
        if (3'(s) >= posNext) begin
          paddedWord[(reverse ? 6*s : 18-6*s) +: 6] = FILL_CHAR;
        end
      end
    end else if (!reverse) begin
      if (posNext == 3'd1)      paddedWord[15:0] = 16'o07474;
      else if (posNext == 3'd2) paddedWord[7:0]  = 8'o074;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      pos <= '0;
    end else if (strobe.start) begin
      acc <= '0;
      pos <= '0;
    end else if (strobe.take) begin
      if (wordFull || chBad) begin
        acc <= '0;
        pos <= '0;
      end else begin
        acc <= mergedWord;
        pos <= posNext[1:0];
      end
    end
  end
endmodule

// File: rtl/tapeCtl.sv
module tapeCtl
  import tapePkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdReverse,
  input  logic                cmdNineTrack,
  input  logic                cmdBcd,
  input  logic [CNT_W-1:0]    cmdCount,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                chValid,
  input  logic                chLast,
  input  logic                chBad,
  input  logic                wordFull,
  input  logic                hasChars,
  input  logic [WORD_W-1:0]   mergedWord,
  input  logic [WORD_W-1:0]   paddedWord,
  input  logic [WORD_W-1:0]   partialWord,
  input  logic [1:0]          newCnt,
  input  logic [1:0]          oldCnt,
  output dpStrobe_t           strobe,
  output logic                nineTrack,
  output logic                reverse,
  output logic                bcd,
  output logic                chReady,
  output logic                wrValid,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]   wrData,
  output logic [STATUS_W-1:0] status,
  output logic                busy,
  output logic                done
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  ctlState_t         state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  count;
  logic              termFlag, parFlag, shortFlag, longFlag, fillFlag;
  logic [1:0]        lastCnt;

  logic              take, storeNow, doTerm, goFill;
  logic              setPar, setShort, setLong;
  logic [WORD_W-1:0] storeWord;
  logic [1:0]        storeCnt;
  logic [ADDR_W-1:0] storeAddr, nextAddr;

  assign busy    = (state != ST_IDLE);
  assign chReady = (state == ST_RUN);
  assign take    = chReady && chValid;
  assign strobe  = '{start: (state == ST_IDLE) && cmdValid, take: take};
  assign status  = {busy, lastCnt, fillFlag, longFlag, shortFlag, parFlag, termFlag};

  always_comb begin
    storeAddr = reverse ? addr - ADDR_ONE : addr;
    nextAddr  = reverse ? addr - ADDR_ONE : addr + ADDR_ONE;
    storeNow  = 1'b0;
    doTerm    = 1'b0;
    goFill    = 1'b0;
    setPar    = 1'b0;
    setShort  = 1'b0;
    setLong   = 1'b0;
    storeWord = mergedWord;
    storeCnt  = newCnt;
    if (chBad) begin
      storeNow  = hasChars;
      storeWord = partialWord;
      storeCnt  = oldCnt;
      doTerm    = 1'b1;
      setPar    = 1'b1;
    end else if (chLast) begin
      storeNow  = 1'b1;
      storeWord = paddedWord;
      doTerm    = 1'b1;
      setLong   = (count != CNT_ONE);
      goFill    = setLong && bcd;
    end else if (wordFull) begin
      storeNow  = 1'b1;
      doTerm    = (count == CNT_ONE);
      setShort  = (count == CNT_ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addr      <= '0;
      count     <= '0;
      nineTrack <= 1'b0;
      reverse   <= 1'b0;
      bcd       <= 1'b0;
      termFlag  <= 1'b0;
      parFlag   <= 1'b0;
      shortFlag <= 1'b0;
      longFlag  <= 1'b0;
      fillFlag  <= 1'b0;
      lastCnt   <= '0;
      wrValid   <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      done      <= 1'b0;
    end else begin
      wrValid <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            addr      <= cmdAddr;
            count     <= cmdCount;
            nineTrack <= cmdNineTrack;
            reverse   <= cmdReverse;
            bcd       <= cmdBcd;
            parFlag   <= 1'b0;
            shortFlag <= 1'b0;
            longFlag  <= 1'b0;
            fillFlag  <= 1'b0;
            lastCnt   <= '0;
            if (cmdCount == '0) begin
              termFlag <= 1'b1;
              done     <= 1'b1;
            end else begin
              termFlag <= 1'b0;
              state    <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (take) begin
            if (storeNow) begin
              wrValid <= 1'b1;
              wrAddr  <= storeAddr;
              wrData  <= storeWord;
              addr    <= nextAddr;
              count   <= count - CNT_ONE;
              lastCnt <= storeCnt;
            end
            if (setPar)   parFlag   <= 1'b1;
            if (setShort) shortFlag <= 1'b1;
            if (setLong)  longFlag  <= 1'b1;
            if (doTerm) begin
              if (goFill) begin
                state <= ST_FILL;
              end else begin
                state    <= ST_IDLE;
                termFlag <= 1'b1;
                done     <= 1'b1;
              end
            end
          end
        end
        ST_FILL: begin
          wrValid  <= 1'b1;
          wrAddr   <= storeAddr;
          wrData   <= FILL_WORD;
          addr     <= nextAddr;
          fillFlag <= 1'b1;
          termFlag <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tapeRecordPacker.sv
module tapeRecordPacker
  import tapePkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdReverse,
  input  logic                cmdNineTrack,
  input  logic                cmdBcd,
  input  logic [CNT_W-1:0]    cmdCount,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                chValid,
  input  logic [7:0]          chData,
  input  logic                chLast,
  output logic                chReady,
  output logic                wrValid,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]   wrData,
  output logic [STATUS_W-1:0] status,
  output logic                busy,
  output logic                done
);
  dpStrobe_t         strobe;
  logic              nineTrack, reverse, bcd;
  logic              chBad, wordFull, hasChars;
  logic [WORD_W-1:0] mergedWord, paddedWord, partialWord;
  logic [1:0]        newCnt, oldCnt;

  tapeWordDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .nineTrack(nineTrack), .reverse(reverse), .bcd(bcd),
    .chData(chData), .chBad(chBad), .wordFull(wordFull), .hasChars(hasChars),
    .mergedWord(mergedWord), .paddedWord(paddedWord), .partialWord(partialWord),
    .newCnt(newCnt), .oldCnt(oldCnt)
  );

  tapeCtl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReverse(cmdReverse), .cmdNineTrack(cmdNineTrack),
    .cmdBcd(cmdBcd), .cmdCount(cmdCount), .cmdAddr(cmdAddr),
    .chValid(chValid), .chLast(chLast),
    .chBad(chBad), .wordFull(wordFull), .hasChars(hasChars),
    .mergedWord(mergedWord), .paddedWord(paddedWord), .partialWord(partialWord),
    .newCnt(newCnt), .oldCnt(oldCnt),
    .strobe(strobe), .nineTrack(nineTrack), .reverse(reverse), .bcd(bcd),
    .chReady(chReady), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .status(status), .busy(busy), .done(done)
  );
endmodule

// File: rtl/tapeRecordPackerChk.sv
module tapeRecordPackerChk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReverse,
  input logic              chReady,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        status,
  input logic              busy,
  input logic              done
);
  logic              revSeen;
  logic              havePrev;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      revSeen  <= 1'b0;
      havePrev <= 1'b0;
      prevAddr <= '0;
    end else if (cmdValid && !busy) begin
      revSeen  <= cmdReverse;
      havePrev <= 1'b0;
    end else if (wrValid) begin
      havePrev <= 1'b1;
      prevAddr <= wrAddr;
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_term_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (status[0] && !busy));
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (status[4:0] == 5'd0));
  assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    chReady |-> busy);
  assert_write_in_xfer_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(busy));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && havePrev) |->
      (wrAddr == (revSeen ? prevAddr - ADDR_W'(1) : prevAddr + ADDR_W'(1))));
endmodule

bind tapeRecordPacker tapeRecordPackerChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReverse(cmdReverse),
  .chReady(chReady), .wrValid(wrValid), .wrAddr(wrAddr), .status(status),
  .busy(busy), .done(done)
);

// File: tb/tapeRecordPacker_bench.sv
`timescale 1ns/1ps
module tapeRecordPacker_bench;
  localparam int N = 12;
  // stimulus columns
  localparam int vRev [N]  = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1};
  localparam int vNine[N]  = '{0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 1};
  localparam int vBcd [N]  = '{0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0};
  localparam int vCnt [N]  = '{10, 10, 2, 5, 5, 4, 3, 10, 10, 3, 2, 4};
  localparam int vAddr[N]  = '{16, 200, 300, 400, 500, 100, 0, 600, 700, 32767, 800, 50};
  localparam int vLen [N]  = '{8, 6, 12, 7, 8, 5, 6, 12, 12, 8, 8, 4};
  localparam int vBad [N]  = '{-1, -1, -1, -1, -1, -1, -1, 5, 4, -1, -1, -1};
  // expected-result columns
  localparam int vStat[N]  = '{8'h09, 8'h59, 8'h05, 8'h29, 8'h49, 8'h29, 8'h79,
                                8'h23, 8'h03, 8'h09, 8'h01, 8'h29};
  localparam int vWr  [N]  = '{2, 3, 2, 3, 3, 2, 3, 2, 1, 2, 2, 2};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdReverse = 1'b0, cmdNineTrack = 1'b0, cmdBcd = 1'b0;
  logic [14:0] cmdCount = '0, cmdAddr = '0;
  logic        chValid = 1'b0, chLast = 1'b0;
  logic [7:0]  chData = '0;
  logic        chReady, wrValid, busy, done;
  logic [14:0] wrAddr;
  logic [23:0] wrData;
  logic [7:0]  status;

  int checks = 0, errors = 0, cycles = 0;
  int capN = 0, doneCnt = 0;
  logic [14:0] capA [8];
  logic [23:0] capD [8];
  logic [7:0]  capStat = '0;
  int expN;
  logic [14:0] expA [8];
  logic [23:0] expD [8];

  tapeRecordPacker u_tapeRecordPacker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReverse(cmdReverse),
    .cmdNineTrack(cmdNineTrack), .cmdBcd(cmdBcd), .cmdCount(cmdCount),
    .cmdAddr(cmdAddr), .chValid(chValid), .chData(chData), .chLast(chLast),
    .chReady(chReady), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .status(status), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (wrValid && capN < 8) begin
      capA[capN] = wrAddr;
      capD[capN] = wrData;
    end
    if (wrValid) capN++;
    if (done) begin
      doneCnt++;
      capStat = status;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      summary();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(int v);
    case (v)
      0: return "R1";   1: return "R3_R7"; 2: return "R6";  3: return "R4";
      4: return "R4";   5: return "R8";    6: return "R8";  7: return "R2";
      8: return "R2";   9: return "R5";    10: return "R6"; default: return "R8";
    endcase
  endfunction

  function automatic logic [5:0] data6(int v, int i);
    return 6'((i * 11 + v * 5 + 3) & 63);
  endfunction

  function automatic logic [7:0] charOf(int v, int i);
    logic [5:0] d;
    logic p;
    if (vNine[v] != 0) return 8'((i * 37 + v * 13 + 5) & 255);
    d = data6(v, i);
    p = (^d) ^ (vBcd[v] == 0);
    if (i == vBad[v]) p = ~p;
    return {1'b0, p, d};
  endfunction

  task automatic push(logic [23:0] w, input int rev, inout int a, inout int cnt);
    if (rev != 0) a = (a - 1) & 32767;
    expA[expN] = 15'(a);
    expD[expN] = w;
    expN++;
    if (rev == 0) a = (a + 1) & 32767;
    cnt--;
  endtask

  task automatic buildExpect(int v);
    int per, p, cnt, a, sh, rev;
    logic [23:0] w;
    rev = vRev[v];
    per = (vNine[v] != 0) ? 3 : 4;
    p = 0; w = '0; cnt = vCnt[v]; a = vAddr[v]; expN = 0;
    for (int i = 0; i < vLen[v]; i++) begin
      if (i == vBad[v]) begin
        if (p > 0) push(w, rev, a, cnt);
        break;
      end
      if (vNine[v] != 0) begin
        sh = (rev != 0) ? 8 * p : 16 - 8 * p;
        w |= 24'(charOf(v, i)) << sh;
      end else begin
        sh = (rev != 0) ? 6 * p : 18 - 6 * p;
        w |= 24'(data6(v, i)) << sh;
      end
      p++;
      if (i == vLen[v] - 1) begin
        if (vNine[v] == 0) begin
          for (int s = p; s < 4; s++) w |= 24'(6'o74) << ((rev != 0) ? 6 * s : 18 - 6 * s);
        end else if (rev == 0) begin
          if (p == 1) w |= 24'o07474;
          else if (p == 2) w |= 24'o074;
        end
        push(w, rev, a, cnt);
        if (cnt > 0 && vBcd[v] != 0) push(24'o74747474, rev, a, cnt);
        break;
      end
      if (p == per) begin
        push(w, rev, a, cnt);
        w = '0; p = 0;
        if (cnt == 0) break;
      end
    end
  endtask

  task automatic runVector(int v, bit interfere);
    int i;
    capN = 0; doneCnt = 0;
    @(negedge clk);
    cmdReverse = vRev[v][0]; cmdNineTrack = vNine[v][0]; cmdBcd = vBcd[v][0];
    cmdCount = 15'(vCnt[v]); cmdAddr = 15'(vAddr[v]); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    i = 0;
    while (busy) begin
      // R11: a command offered mid-transfer must not disturb it
      if (interfere && i == 3) begin
        cmdValid = 1'b1; cmdAddr = 15'd999; cmdNineTrack = ~cmdNineTrack; cmdCount = 15'd1;
      end else cmdValid = 1'b0;
      if (chReady && i < vLen[v]) begin
        chValid = 1'b1; chData = charOf(v, i); chLast = (i == vLen[v] - 1);
        i++;
      end else chValid = 1'b0;
      @(negedge clk);
    end
    chValid = 1'b0; chLast = 1'b0; cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    buildExpect(v);
    check(tagOf(v), "R9 status", int'(capStat), vStat[v]);
    check(tagOf(v), "write count", capN, vWr[v]);
    check(tagOf(v), "R9 done pulses", doneCnt, 1);
    for (int k = 0; k < expN && k < capN && k < 8; k++) begin
      check(tagOf(v), "R5 write address", int'(capA[k]), int'(expA[k]));
      check(tagOf(v), "write data", int'(capD[k]), int'(expD[k]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "status in reset", int'(status), 0);
    check("R12", "busy/ready/wr/done", int'({busy, chReady, wrValid, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "status after reset", int'(status), 0);

    for (int v = 0; v < N; v++) runVector(v, 1'b0);

    // R11 command ignored while busy
    runVector(0, 1'b1);

    // R10 zero count
    capN = 0; doneCnt = 0;
    cmdCount = 15'd0; cmdAddr = 15'd5; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R10", "done right after zero-count command", int'(done), 1);
    repeat (3) @(negedge clk);
    check("R10", "status", int'(capStat), 8'h01);
    check("R10", "writes", capN, 0);
    check("R10", "done pulses", doneCnt, 1);

    // R11 characters ignored while idle
    capN = 0; doneCnt = 0;
    for (int k = 0; k < 3; k++) begin
      chValid = 1'b1; chData = 8'h55; chLast = (k == 2);
      @(negedge clk);
      check("R11", "ready while idle", int'(chReady), 0);
    end
    chValid = 1'b0; chLast = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "idle writes", capN, 0);
    check("R11", "idle status kept", int'(status), 8'h01);
    summary();
  end
endmodule